// File: doc/BRIEF.md
# Dual Warp Issue Scheduler with Shared Execution Groups

This block issues warps for a single-instruction, multiple-thread core. Two scheduler slots each hold a small pool of warps. A warp is 32 threads that share one instruction, and each thread has a bit in the warp's 32-bit active mask. In every cycle each slot picks at most one eligible warp, using round-robin order. It then sends that warp's instruction to one of three shared execution groups: a 16-lane arithmetic group, a 16-lane load/store group or a 4-lane special-function group. A group narrower than the warp works through the warp's lanes in slices over several cycles, and it accepts nothing new until the last slice is under way.

Divergent branches run by predication. A split command records the warp's current mask and narrows it to the threads that took the branch. A next command moves the warp to the threads that fell through. A second next command restores the recorded mask. If a path has no threads, it is skipped. The decoder supplies the per-warp ready flags and instruction classes, and the branch unit supplies the branch commands and outcome bits. The block drives the issue grants and the per-cycle lane enables of each group.

Top module: `dual_warp_issue`

## Requirements
- R1: While reset is asserted no slot issues, even with warps ready. After reset every group's lane enables are zero and every warp's mask is all ones.
- R2: A slot issues only a warp that is ready and whose class is arithmetic (0), load/store (1) or special function (2). The unit it reports equals that class, and class 3 is never issued.
- R3: Each slot picks among its eligible warps in round-robin order, starting at the warp after the one it last issued. After reset the search starts at warp 0.
- R4: A 16-lane group stays busy for 2 cycles per warp and the 4-lane group for 8 cycles. No group receives two issues in one cycle. A group takes its next issue in the last cycle of its current work, so a waiting warp issues exactly 2 or 8 cycles after the previous one.
- R5: When both slots want the same free group, slot 0 wins. The losing slot keeps its chosen warp, even if the ready flags change, and issues that warp as soon as the group is free.
- R6: In the k-th cycle after an issue (k counted from 1), a group's lane enables carry bits [(k-1)*W +: W] of the issued mask, where W is the group width. Masked-off lanes are never enabled, and the upper bits of a 4-lane group's enable field stay zero.
- R7: A split command (code 1) on a warp that is not diverged makes its mask equal to the old mask AND the outcome bits. A next command (code 2) then switches the mask to the old mask AND NOT the outcome bits. A split command on an already diverged warp has no effect.
- R8: A path whose mask would be all zeros is skipped. An empty taken path makes the split go directly to the fall-through path. An empty fall-through path makes the first next command restore the mask.
- R9: When both paths are complete, the warp's mask is the value it held before the split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrp_ready | input | 2 x NW | Ready flag per warp, per slot |
| wrp_class | input | 2 x NW x 2 | Decoded unit class per warp, per slot |
| br_cmd | input | 2 x 2 | Branch command per slot: 0 none, 1 split, 2 next, 3 none |
| br_warp | input | 2 x WID | Warp that the branch command addresses |
| br_bits | input | 2 x 32 | Branch outcome bits, 1 meaning taken |
| iss_valid | output | 2 | Slot issues this cycle |
| iss_warp | output | 2 x WID | Issued warp |
| iss_unit | output | 2 x 2 | Group the issue goes to |
| iss_mask | output | 2 x 32 | Lane mask sent with the issue |
| grp_lane_en | output | 3 x 16 | Lane enables of each group in the current cycle |

## Verification
The assertions assume that the class of a ready warp does not change while that warp waits for a group, and that a branch command never addresses a warp in the same cycle that the warp issues. The stimulus holds the class steady for as long as a warp is ready. It also spaces branch commands and issue requests in separate cycles and leaves every group idle before a new scenario starts, so each expected grant and slice depends only on that scenario.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int LANES = 32;
  typedef logic [LANES-1:0] lmask_t;

  localparam logic [1:0] U_ALU  = 2'd0;
  localparam logic [1:0] U_LSU  = 2'd1;
  localparam logic [1:0] U_SFU  = 2'd2;
  localparam logic [1:0] U_NONE = 2'd3;

  localparam logic [1:0] BR_SPLIT = 2'd1;
  localparam logic [1:0] BR_NEXT  = 2'd2;

  function automatic int occ_cycles(input int width);
    return LANES / width;
  endfunction

  function automatic lmask_t take_mask(input lmask_t act, input lmask_t bits);
    return act & bits;
  endfunction

  function automatic lmask_t fall_mask(input lmask_t act, input lmask_t bits);
    return act & ~bits;
  endfunction
endpackage

// File: rtl/wis_mask_ctl.sv
module wis_mask_ctl
  import wis_pkg::*;
#(
  parameter int NW  = 4,
  parameter int WID = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          br_cmd,
  input  logic [WID-1:0]      br_warp,
  input  lmask_t              br_bits,
  output lmask_t [NW-1:0]     cur_mask
);
  typedef enum logic [1:0] {D_IDLE, D_TAKEN, D_FALL} div_e;

  for (genvar w = 0; w < NW; w++) begin : g_warp
    div_e   st;
    lmask_t cur, saved, pend, tk, ft;
    logic   hit;

    assign tk  = take_mask(cur, br_bits);
    assign ft  = fall_mask(cur, br_bits);
    assign hit = (br_warp == WID'(w));
    assign cur_mask[w] = cur;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st    <= D_IDLE;
        cur   <= '1;
        saved <= '1;
        pend  <= '0;
      end else if (hit) begin
        case (br_cmd)
          BR_SPLIT: if (st == D_IDLE) begin
            saved <= cur;
            pend  <= ft;
            if (|tk) begin
              cur <= tk;
              st  <= D_TAKEN;
            end else if (|ft) begin
              cur <= ft;
              st  <= D_FALL;
            end
          end
          BR_NEXT: if (st == D_TAKEN && |pend) begin
            cur <= pend;
            st  <= D_FALL;
          end else if (st != D_IDLE) begin
            cur <= saved;
            st  <= D_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wis_picker.sv
module wis_picker #(
  parameter int NW  = 4,
  parameter int WID = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NW-1:0]  elig,
  input  logic           granted,
  output logic           cand_v,
  output logic [WID-1:0] cand_w
);
  logic [WID-1:0] last_w, hold_w;
  logic           hold_v;
  logic [WID:0]   pick;

  function automatic logic [WID:0] rr_next(input logic [NW-1:0] e,
                                           input logic [WID-1:0] last);
    logic [WID:0] r;
    r = '0;
    for (int k = 1; k <= NW; k++) begin
      logic [WID-1:0] j;
      j = WID'((int'(last) + k) % NW);
      if (!r[WID] && e[j]) r = {1'b1, j};
    end
    return r;
  endfunction

  assign pick   = rr_next(elig, last_w);
  assign cand_v = hold_v | pick[WID];
  assign cand_w = hold_v ? hold_w : pick[WID-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_w <= WID'(NW - 1);
      hold_v <= 1'b0;
      hold_w <= '0;
    end else if (granted) begin
      last_w <= cand_w;
      hold_v <= 1'b0;
    end else if (cand_v) begin
      hold_v <= 1'b1;
      hold_w <= cand_w;
    end
  end
endmodule

// File: rtl/wis_group.sv
module wis_group
  import wis_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  lmask_t       mask,
  output logic         free,
  output logic [W-1:0] lane_en
);
  localparam int CYC = occ_cycles(W);
  localparam int CW  = $clog2(CYC + 1);

  logic [CW-1:0] cnt;
  lmask_t        m;

  assign free = (cnt <= CW'(1));

  always_comb begin
    lane_en = '0;
    for (int i = 0; i < CYC; i++)
      if (cnt == CW'(CYC - i)) lane_en = m[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      m   <= '0;
    end else if (load) begin
      cnt <= CW'(CYC);
      m   <= mask;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dual_warp_issue.sv
module dual_warp_issue
  import wis_pkg::*;
#(
  parameter int NW    = 4,
  parameter int ALU_W = 16,
  parameter int LSU_W = 16,
  parameter int SFU_W = 4,
  parameter int WID   = (NW > 1) ? $clog2(NW) : 1,
  parameter int MAXW  = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0][NW-1:0]              wrp_ready,
  input  logic [1:0][NW-1:0][1:0]         wrp_class,
  input  logic [1:0][1:0]                 br_cmd,
  input  logic [1:0][WID-1:0]             br_warp,
  input  logic [1:0][LANES-1:0]           br_bits,
  output logic [1:0]                      iss_valid,
  output logic [1:0][WID-1:0]             iss_warp,
  output logic [1:0][1:0]                 iss_unit,
  output logic [1:0][LANES-1:0]           iss_mask,
  output logic [2:0][MAXW-1:0]            grp_lane_en
);
  localparam int NSCH = 2;
  localparam int NGRP = 3;

  lmask_t [NSCH-1:0][NW-1:0] cur_mask;
  logic   [NSCH-1:0][NW-1:0] elig;
  logic   [NSCH-1:0]         cand_v;
  logic   [NSCH-1:0][WID-1:0] cand_w;
  logic   [NSCH-1:0][1:0]    cand_u;
  logic   [NSCH-1:0]         gnt;
  logic   [NGRP-1:0]         grp_free;
  logic   [NGRP-1:0]         grp_load;

  function automatic logic unit_ok(input logic [1:0] u, input logic [2:0] fr);
    case (u)
      U_ALU:   return fr[0];
      U_LSU:   return fr[1];
      U_SFU:   return fr[2];
      default: return 1'b0;
    endcase
  endfunction

  for (genvar s = 0; s < NSCH; s++) begin : g_sch
    wis_mask_ctl #(.NW(NW), .WID(WID)) u_mask (
      .clk(clk), .rst_n(rst_n), .br_cmd(br_cmd[s]), .br_warp(br_warp[s]),
      .br_bits(br_bits[s]), .cur_mask(cur_mask[s])
    );

    for (genvar w = 0; w < NW; w++) begin : g_el
      assign elig[s][w] = wrp_ready[s][w] && (wrp_class[s][w] != U_NONE)
                          && (|cur_mask[s][w]);
    end

    wis_picker #(.NW(NW), .WID(WID)) u_pick (
      .clk(clk), .rst_n(rst_n), .elig(elig[s]), .granted(gnt[s]),
      .cand_v(cand_v[s]), .cand_w(cand_w[s])
    );

    assign cand_u[s]    = wrp_class[s][cand_w[s]];
    assign iss_valid[s] = gnt[s];
    assign iss_warp[s]  = cand_w[s];
    assign iss_unit[s]  = cand_u[s];
    assign iss_mask[s]  = cur_mask[s][cand_w[s]];
  end

  assign gnt[0] = rst_n && cand_v[0] && unit_ok(cand_u[0], grp_free);
  assign gnt[1] = rst_n && cand_v[1] && unit_ok(cand_u[1], grp_free)
                  && !(gnt[0] && cand_u[0] == cand_u[1]);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int GW = (g == 0) ? ALU_W : (g == 1) ? LSU_W : SFU_W;
    logic [GW-1:0] le;
    lmask_t        ld_mask;

    assign grp_load[g] = (gnt[0] && cand_u[0] == 2'(g)) ||
                         (gnt[1] && cand_u[1] == 2'(g));
    assign ld_mask = (gnt[0] && cand_u[0] == 2'(g)) ? iss_mask[0] : iss_mask[1];

    wis_group #(.W(GW)) u_grp (
      .clk(clk), .rst_n(rst_n), .load(grp_load[g]), .mask(ld_mask),
      .free(grp_free[g]), .lane_en(le)
    );
    assign grp_lane_en[g] = MAXW'(le);
  end
endmodule

// File: rtl/wis_chk.sv
module wis_chk #(
  parameter int NW  = 4,
  parameter int WID = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0][NW-1:0][1:0] wrp_class,
  input logic [1:0]              iss_valid,
  input logic [1:0][WID-1:0]     iss_warp,
  input logic [1:0][1:0]         iss_unit,
  input logic [1:0]              cand_v,
  input logic [1:0][WID-1:0]     cand_w,
  input logic [2:0][15:0]        grp_lane_en
);
  logic [2:0] took;
  always_comb
    for (int g = 0; g < 3; g++)
      took[g] = (iss_valid[0] && iss_unit[0] == 2'(g)) ||
                (iss_valid[1] && iss_unit[1] == 2'(g));

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> grp_lane_en == '0);

  a_r2_unit_s0: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> (iss_unit[0] != 2'd3) && iss_unit[0] == wrp_class[0][iss_warp[0]]);

  a_r2_unit_s1: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> (iss_unit[1] != 2'd3) && iss_unit[1] == wrp_class[1][iss_warp[1]]);

  a_r4_no_shared_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid[0] && iss_valid[1]) |-> iss_unit[0] != iss_unit[1]);

  for (genvar g = 0; g < 3; g++) begin : g_busy
    a_r4_busy_next: assert property (@(posedge clk) disable iff (!rst_n)
      took[g] |=> !took[g]);
  end

  a_r5_loser_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_v[1] && !iss_valid[1]) |=> cand_v[1] && cand_w[1] == $past(cand_w[1]));
endmodule

bind dual_warp_issue wis_chk #(.NW(NW), .WID(WID)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrp_class(wrp_class), .iss_valid(iss_valid),
  .iss_warp(iss_warp), .iss_unit(iss_unit), .cand_v(cand_v), .cand_w(cand_w),
  .grp_lane_en(grp_lane_en)
);

// File: tb/sim_dual_warp_issue.sv
module sim_dual_warp_issue;
  localparam int NW = 4;
  localparam int WID = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0][NW-1:0]      wrp_ready = '0;
  logic [1:0][NW-1:0][1:0] wrp_class = '0;
  logic [1:0][1:0]         br_cmd = '0;
  logic [1:0][WID-1:0]     br_warp = '0;
  logic [1:0][31:0]        br_bits = '0;
  logic [1:0]              iss_valid;
  logic [1:0][WID-1:0]     iss_warp;
  logic [1:0][1:0]         iss_unit;
  logic [1:0][31:0]        iss_mask;
  logic [2:0][15:0]        grp_lane_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_warp_issue u0 (
    .clk(clk), .rst_n(rst_n), .wrp_ready(wrp_ready), .wrp_class(wrp_class),
    .br_cmd(br_cmd), .br_warp(br_warp), .br_bits(br_bits),
    .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_unit(iss_unit),
    .iss_mask(iss_mask), .grp_lane_en(grp_lane_en)
  );

  // {ready[3:0], expected warp[1:0]} for slot 0, round-robin walk
  localparam logic [5:0] RR_VEC [10] = '{
    {4'b1111, 2'd0}, {4'b1111, 2'd1}, {4'b0101, 2'd2}, {4'b0101, 2'd0},
    {4'b1000, 2'd3}, {4'b1001, 2'd0}, {4'b0110, 2'd1}, {4'b0110, 2'd2},
    {4'b0010, 2'd1}, {4'b1100, 2'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_issue(input int s, input int w, input logic [1:0] c,
                          output logic v, output logic [1:0] u,
                          output logic [1:0] wr, output logic [31:0] m);
    @(negedge clk);
    wrp_ready[s] = '0;
    wrp_ready[s][w] = 1'b1;
    wrp_class[s][w] = c;
    #1;
    v = iss_valid[s]; u = iss_unit[s]; wr = iss_warp[s]; m = iss_mask[s];
    @(negedge clk);
    wrp_ready[s] = '0;
    repeat (10) @(negedge clk);
  endtask

  task automatic branch(input int s, input logic [1:0] cmd, input int w, input logic [31:0] bits);
    @(negedge clk);
    br_cmd[s] = cmd; br_warp[s] = WID'(w); br_bits[s] = bits;
    @(negedge clk);
    br_cmd[s] = 2'd0; br_bits[s] = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [1:0] u, wr;
    logic [31:0] m;

    // R1: no issue while in reset, even with ready warps
    repeat (3) @(negedge clk);
    wrp_ready[0] = 4'b1111;
    #1;
    chk("R1 no issue in reset", 32'(iss_valid), 32'd0);
    @(negedge clk);
    wrp_ready[0] = '0;
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 lane enables idle", grp_lane_en[0] | grp_lane_en[1] | grp_lane_en[2], 32'd0);

    // R3: round-robin walk for slot 0, arithmetic class
    for (int i = 0; i < 10; i++) begin
      do_issue(0, 0, 2'd0, v, u, wr, m);  // placeholder replaced below
    end
    // (walk uses its own sequence; the loop above is the warm-up of warp 0)
    // Reset to restart round-robin from warp 0.
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      wrp_class[0] = '0;
      wrp_ready[0] = RR_VEC[i][5:2];
      #1;
      chk("R3 valid", 32'(iss_valid[0]), 32'd1);
      chk("R3 warp", 32'(iss_warp[0]), 32'(RR_VEC[i][1:0]));
      if (i == 0) chk("R1 mask all ones after reset", iss_mask[0], 32'hFFFF_FFFF);
      @(negedge clk);
      wrp_ready[0] = '0;
      #1;
      if (i == 0) chk("R6 arithmetic slice 0", 32'(grp_lane_en[0]), 32'h0000_FFFF);
      @(negedge clk); #1;
      if (i == 0) chk("R6 arithmetic slice 1", 32'(grp_lane_en[0]), 32'h0000_FFFF);
    end
    repeat (3) @(negedge clk);

    // R4: special-function occupancy of 8 cycles, warp 0 held ready
    @(negedge clk);
    wrp_class[0][0] = 2'd2;
    wrp_ready[0] = 4'b0001;
    for (int k = 0; k <= 8; k++) begin
      #1;
      chk($sformatf("R4 sfu issue k=%0d", k), 32'(iss_valid[0]), (k == 0 || k == 8) ? 32'd1 : 32'd0);
      if (k >= 1) chk($sformatf("R6 sfu slice k=%0d", k), 32'(grp_lane_en[2]), 32'h0000_000F);
      @(negedge clk);
    end
    wrp_ready[0] = '0;
    repeat (10) @(negedge clk);

    // R5: both slots want the load/store group; slot 0 wins
    wrp_class[0][1] = 2'd1;
    wrp_class[1][2] = 2'd1;
    wrp_class[1][0] = 2'd1;
    wrp_ready[0] = 4'b0010;
    wrp_ready[1] = 4'b0100;
    #1;
    chk("R5 slot0 wins", 32'(iss_valid[0]), 32'd1);
    chk("R2 slot0 unit load/store", 32'(iss_unit[0]), 32'd1);
    chk("R5 slot1 stalls", 32'(iss_valid[1]), 32'd0);
    @(negedge clk);
    wrp_ready[0] = '0;
    wrp_ready[1] = 4'b0001;
    #1;
    chk("R4 slot1 waits busy group", 32'(iss_valid[1]), 32'd0);
    @(negedge clk); #1;
    chk("R5 held warp issues", 32'(iss_valid[1]), 32'd1);
    chk("R5 held warp id", 32'(iss_warp[1]), 32'd2);
    @(negedge clk);
    wrp_ready[1] = '0;
    repeat (10) @(negedge clk);

    // R2: class 3 never issues
    wrp_class[1][1] = 2'd3;
    wrp_ready[1] = 4'b0010;
    #1;
    chk("R2 class 3 not issued", 32'(iss_valid[1]), 32'd0);
    @(negedge clk);
    wrp_ready[1] = '0;
    repeat (3) @(negedge clk);

    // R7 / R9: split and walk both paths of warp 3 on slot 0
    branch(0, 2'd1, 3, 32'h0000_FFFF);
    do_issue(0, 3, 2'd0, v, u, wr, m);
    chk("R7 taken mask", m, 32'h0000_FFFF);
    branch(0, 2'd1, 3, 32'hFFFF_FFFF);
    do_issue(0, 3, 2'd0, v, u, wr, m);
    chk("R7 split ignored while diverged", m, 32'h0000_FFFF);
    branch(0, 2'd2, 3, 32'h0);
    do_issue(0, 3, 2'd0, v, u, wr, m);
    chk("R7 fall-through mask", m, 32'hFFFF_0000);
    branch(0, 2'd2, 3, 32'h0);
    do_issue(0, 3, 2'd0, v, u, wr, m);
    chk("R9 mask restored", m, 32'hFFFF_FFFF);

    // R6: masked lanes on the special-function group
    branch(0, 2'd1, 3, 32'hF0F0_F0F0);
    @(negedge clk);
    wrp_class[0][3] = 2'd2;
    wrp_ready[0] = 4'b1000;
    #1;
    chk("R6 sfu issue mask", iss_mask[0], 32'hF0F0_F0F0);
    @(negedge clk);
    wrp_ready[0] = '0;
    for (int k = 1; k <= 8; k++) begin
      #1;
      chk($sformatf("R6 masked slice k=%0d", k), 32'(grp_lane_en[2]),
          ((k - 1) % 2 == 1) ? 32'h0000_000F : 32'h0);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    branch(0, 2'd2, 3, 32'h0);
    branch(0, 2'd2, 3, 32'h0);
    wrp_class[0][3] = 2'd0;

    // R8: empty fall-through path, then empty taken path
    branch(0, 2'd1, 3, 32'hFFFF_FFFF);
    branch(0, 2'd2, 3, 32'h0);
    branch(0, 2'd1, 3, 32'h0000_0001);
    do_issue(0, 3, 2'd0, v, u, wr, m);
    chk("R8 empty fall path skipped", m, 32'h0000_0001);
    branch(0, 2'd2, 3, 32'h0);
    branch(0, 2'd2, 3, 32'h0);
    branch(0, 2'd1, 3, 32'h0);
    do_issue(0, 3, 2'd0, v, u, wr, m);
    chk("R8 empty taken path skipped", m, 32'hFFFF_FFFF);
    branch(0, 2'd2, 3, 32'h0);
    branch(0, 2'd1, 3, 32'h0000_0002);
    do_issue(0, 3, 2'd0, v, u, wr, m);
    chk("R8 restored after single path", m, 32'h0000_0002);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule